// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the processor core last restarted and tells the fetch unit where to resume. It holds an 8-bit status word whose flags are updated by single-cycle event strobes from the reset and power-management logic. The strobes cover power-on, brown-out, an external reset while running or while asleep, a software reset instruction, a watchdog reset or wake-up, an interrupt wake-up, and a stack full or stack underflow reset. Each event sets, clears or keeps its own subset of flags. Firmware reads the word after restart to find the cause, and may rewrite it through a simple write port.

For every event the block also computes the restart address and pulses a load strobe for the program counter. A reset restarts at address zero. A wake-up from sleep resumes two bytes past the current program counter, unless an interrupt caused the wake-up and a global interrupt enable is set. In that case the matching interrupt vector is loaded. The block also keeps two sticky stack-error outputs.

Top module: `rst_cause_reg`

## Requirements
- R1: Reset input or a power-on event (event bit 0) loads the status word with 0x1C, clears both stack outputs, and loads address 0. In the status word, bit 7 is priority enable, bit 6 is table-write lock, bit 5 always reads 0, bit 4 is the software-reset flag, bit 3 is the watchdog time-out flag, bit 2 is the power-down flag, bit 1 is the power-on flag and bit 0 is the brown-out flag.
- R2: A software reset event (event bit 4) clears bit 4 and keeps bits 3..0.
- R3: A watchdog reset event (event bit 5) clears bit 3, sets bit 2, and keeps bits 4, 1 and 0.
- R4: An external reset during sleep (event bit 3) sets bit 3, clears bit 2, and keeps bits 4, 1 and 0. An external reset while running (event bit 2) keeps bits 4..0.
- R5: A brown-out event (event bit 1) sets bits 4, 3 and 2, clears bit 0, and keeps bit 1.
- R6: A watchdog wake-up (event bit 6) clears bits 3 and 2. An interrupt wake-up (event bit 7) sets bit 3 and clears bit 2. Both keep bits 4, 1 and 0.
- R7: Stack full (event bit 8) and stack underflow (event bit 9) keep bits 4..0 and set their own sticky output. Only R1 clears these outputs.
- R8: Wake-up events keep bits 7 and 6. Power-on and stack events clear both bits. Every other reset event clears bit 7 and keeps bit 6.
- R9: The cycle after any event, the program-counter load strobe is high for exactly one cycle. For a reset event the new address is 0. For a watchdog wake-up it is the current address plus 2, modulo 2^PC_W.
- R10: On an interrupt wake-up, the new address is 0x08 when the high enable is set. It is 0x18 when only the low enable is set, and the current address plus 2 when neither is set.
- R11: A software write with no event stores the data with bit 5 forced to 0. If any event arrives in the same cycle, the write is discarded.
- R12: When several event bits are set together, only the lowest-numbered one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset, same effect as a power-on event |
| evt_i | input | 10 | Event strobes, bit numbering as in the requirements |
| irq_hi_en_i | input | 1 | High-priority global interrupt enable |
| irq_lo_en_i | input | 1 | Low-priority global interrupt enable |
| pc_i | input | PC_W | Current program counter |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| stat_o | output | 8 | Status word |
| stk_full_o | output | 1 | Sticky stack-full indication |
| stk_unf_o | output | 1 | Sticky stack-underflow indication |
| pc_o | output | PC_W | Restart address |
| pc_ld_o | output | 1 | One-cycle load strobe for pc_o |

## Verification
Every one of the 256 possible write values is preloaded in turn, and each is followed by each of the ten events. This shows, for every flag, whether an event sets it, clears it or keeps it from both a 0 and a 1 starting value. Neighbouring flags can therefore be distinguished even when their rules differ by a single bit. The two interrupt enables are taken from the preload value, so all four enable combinations meet the interrupt wake-up. Program counters near the top of the address space are used to expose a wrong wrap in the plus-2 path. Separate patterns fire two events at once, and fire a write together with an event, to separate priority order from write suppression.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int EV_N = 10;
    localparam int EV_W = 4;

    typedef enum logic [EV_W-1:0] {
        EV_POR     = 4'd0,
        EV_BOR     = 4'd1,
        EV_XRUN    = 4'd2,
        EV_XSLP    = 4'd3,
        EV_SWRST   = 4'd4,
        EV_WDRST   = 4'd5,
        EV_WDWAKE  = 4'd6,
        EV_IRQWAKE = 4'd7,
        EV_STKFULL = 4'd8,
        EV_STKUNF  = 4'd9
    } ev_e;

    typedef struct packed {
        logic prio_en;
        logic tblwr_lock;
        logic rsvd;
        logic swrst_f;
        logic wdto_f;
        logic sleep_f;
        logic pwron_f;
        logic brnout_f;
    } stat_t;

    localparam logic [7:0] POR_VAL   = 8'h1C;
    localparam logic [7:0] IMPL_MASK = 8'hDF;

    function automatic logic is_wake(ev_e e);
        return (e == EV_WDWAKE) || (e == EV_IRQWAKE);
    endfunction

    function automatic logic is_stack(ev_e e);
        return (e == EV_STKFULL) || (e == EV_STKUNF);
    endfunction

    function automatic stat_t apply_event(stat_t cur, ev_e e);
        stat_t n;
        n      = cur;
        n.rsvd = 1'b0;
        if (!is_wake(e)) n.prio_en = 1'b0;
        case (e)
            EV_POR:     n = stat_t'(POR_VAL);
            EV_BOR: begin
                n.swrst_f  = 1'b1;
                n.wdto_f   = 1'b1;
                n.sleep_f  = 1'b1;
                n.brnout_f = 1'b0;
            end
            EV_XSLP: begin
                n.wdto_f  = 1'b1;
                n.sleep_f = 1'b0;
            end
            EV_SWRST:   n.swrst_f = 1'b0;
            EV_WDRST: begin
                n.wdto_f  = 1'b0;
                n.sleep_f = 1'b1;
            end
            EV_WDWAKE: begin
                n.wdto_f  = 1'b0;
                n.sleep_f = 1'b0;
            end
            EV_IRQWAKE: begin
                n.wdto_f  = 1'b1;
                n.sleep_f = 1'b0;
            end
            EV_STKFULL, EV_STKUNF: n.tblwr_lock = 1'b0;
            default: ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rst_cause_evsel.sv
module rst_cause_evsel
    import rst_cause_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [EV_N-1:0] evt_i,
    output logic            vld_o,
    output ev_e             idx_o
);

    logic [EV_W-1:0] idx_raw;
    logic [EV_N-1:0] below_mask;

    always_comb begin
        idx_raw = '0;
        for (int i = EV_N - 1; i >= 0; i--) begin
            if (evt_i[i]) idx_raw = EV_W'(i);
        end
    end

    assign vld_o = |evt_i;
    assign idx_o = ev_e'(idx_raw);

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < EV_N; i++) begin
            below_mask[i] = (i < int'(idx_raw));
        end
    end

    // R12
    sel_lowest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> (evt_i[idx_raw] && ($countones(evt_i & below_mask) == 0)));

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
    import rst_cause_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ev_vld_i,
    input  ev_e        ev_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output stat_t      stat_o,
    output logic       stk_full_o,
    output logic       stk_unf_o
);

    stat_t stat_q;
    logic  full_q, unf_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= stat_t'(POR_VAL);
            full_q <= 1'b0;
            unf_q  <= 1'b0;
        end else if (ev_vld_i) begin
            stat_q <= apply_event(stat_q, ev_i);
            if (ev_i == EV_POR) begin
                full_q <= 1'b0;
                unf_q  <= 1'b0;
            end
            if (ev_i == EV_STKFULL) full_q <= 1'b1;
            if (ev_i == EV_STKUNF)  unf_q  <= 1'b1;
        end else if (wr_en_i) begin
            stat_q <= stat_t'(wr_data_i & IMPL_MASK);
        end
    end

    assign stat_o     = stat_q;
    assign stk_full_o = full_q;
    assign stk_unf_o  = unf_q;

    // R1
    por_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && ev_i == EV_POR) |=> (stat_q == POR_VAL && !full_q && !unf_q));

    // R7
    stk_full_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && ev_i == EV_STKFULL) |=> (full_q && $stable(stat_q[4:0])));

    // R7
    stk_unf_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && ev_i == EV_STKUNF) |=> (unf_q && $stable(stat_q[4:0])));

    // R8
    wake_enables_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && is_wake(ev_i)) |=> $stable(stat_q[7:6]));

    // R11
    rsvd_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !ev_vld_i) |=> (stat_q[5] == 1'b0));

endmodule

// File: rtl/rst_cause_pcsel.sv
module rst_cause_pcsel
    import rst_cause_pkg::*;
#(
    parameter int PC_W   = 21,
    parameter int VEC_HI = 8,
    parameter int VEC_LO = 24
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            ev_vld_i,
    input  ev_e             ev_i,
    input  logic            irq_hi_en_i,
    input  logic            irq_lo_en_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_o,
    output logic            pc_ld_o
);

    localparam logic [PC_W-1:0] HI_ADDR = PC_W'(VEC_HI);
    localparam logic [PC_W-1:0] LO_ADDR = PC_W'(VEC_LO);
    localparam logic [PC_W-1:0] STEP    = PC_W'(2);

    logic [PC_W-1:0] nxt_pc;
    logic [PC_W-1:0] pc_q;
    logic            ld_q;

    always_comb begin
        nxt_pc = '0;
        if (ev_i == EV_IRQWAKE && irq_hi_en_i)      nxt_pc = HI_ADDR;
        else if (ev_i == EV_IRQWAKE && irq_lo_en_i) nxt_pc = LO_ADDR;
        else if (is_wake(ev_i))                     nxt_pc = pc_i + STEP;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_q <= '0;
            ld_q <= 1'b0;
        end else begin
            ld_q <= ev_vld_i;
            if (ev_vld_i) pc_q <= nxt_pc;
        end
    end

    assign pc_o    = pc_q;
    assign pc_ld_o = ld_q;

    // R9
    ld_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_vld_i |=> pc_ld_o);

    // R9
    ld_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ev_vld_i |=> !pc_ld_o);

    // R9
    reset_addr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && !is_wake(ev_i)) |=> (pc_o == '0));

    // R10
    hi_vec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_vld_i && ev_i == EV_IRQWAKE && irq_hi_en_i) |=> (pc_o == HI_ADDR));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int PC_W   = 21,
    parameter int VEC_HI = 8,
    parameter int VEC_LO = 24
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [9:0]      evt_i,
    input  logic            irq_hi_en_i,
    input  logic            irq_lo_en_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            wr_en_i,
    input  logic [7:0]      wr_data_i,
    output logic [7:0]      stat_o,
    output logic            stk_full_o,
    output logic            stk_unf_o,
    output logic [PC_W-1:0] pc_o,
    output logic            pc_ld_o
);

    logic  ev_vld;
    ev_e   ev_idx;
    stat_t stat;

    rst_cause_evsel u_evsel (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .evt_i (evt_i),
        .vld_o (ev_vld),
        .idx_o (ev_idx)
    );

    rst_cause_flags u_flags (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ev_vld_i   (ev_vld),
        .ev_i       (ev_idx),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .stat_o     (stat),
        .stk_full_o (stk_full_o),
        .stk_unf_o  (stk_unf_o)
    );

    rst_cause_pcsel #(
        .PC_W   (PC_W),
        .VEC_HI (VEC_HI),
        .VEC_LO (VEC_LO)
    ) u_pcsel (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .ev_vld_i    (ev_vld),
        .ev_i        (ev_idx),
        .irq_hi_en_i (irq_hi_en_i),
        .irq_lo_en_i (irq_lo_en_i),
        .pc_i        (pc_i),
        .pc_o        (pc_o),
        .pc_ld_o     (pc_ld_o)
    );

    assign stat_o = stat;

endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;

    localparam int PC_W = 21;

    logic            clk = 1'b0;
    logic            rst;
    logic [9:0]      evt;
    logic            ghi, glo;
    logic [PC_W-1:0] pc_in;
    logic            wr_en;
    logic [7:0]      wr_data;
    logic [7:0]      stat;
    logic            sfull, sunf;
    logic [PC_W-1:0] pc_out;
    logic            pc_ld;

    int n_cmp  = 0;
    int n_fail = 0;
    logic exp_full = 1'b0;
    logic exp_unf  = 1'b0;

    always #2.5 clk = ~clk;

    rst_cause_reg #(.PC_W(PC_W)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .evt_i       (evt),
        .irq_hi_en_i (ghi),
        .irq_lo_en_i (glo),
        .pc_i        (pc_in),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .stat_o      (stat),
        .stk_full_o  (sfull),
        .stk_unf_o   (sunf),
        .pc_o        (pc_out),
        .pc_ld_o     (pc_ld)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(logic [7:0] s, int e);
        logic [7:0] n;
        n = s & 8'hDF;
        case (e)
            0: n = 8'h1C;
            1: n = (n & 8'h42) | 8'h1C;
            2: n = n & 8'h7F;
            3: n = (n & 8'h7B) | 8'h08;
            4: n = n & 8'h6F;
            5: n = (n & 8'h77) | 8'h04;
            6: n = n & 8'hF3;
            7: n = (n & 8'hFB) | 8'h08;
            default: n = n & 8'h3F;
        endcase
        return n;
    endfunction

    function automatic string req_of(int e);
        case (e)
            0: return "R1";
            1: return "R5";
            2, 3: return "R4";
            4: return "R2";
            5: return "R3";
            6, 7: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic do_write(logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 write", 32'(stat), 32'(v & 8'hDF));
    endtask

    task automatic fire(int e, logic [7:0] pre, logic h, logic l, logic [PC_W-1:0] pcv);
        logic [7:0]      es;
        logic [PC_W-1:0] ep;
        @(negedge clk);
        evt = 10'(1) << e; ghi = h; glo = l; pc_in = pcv;
        if (e == 0) begin exp_full = 1'b0; exp_unf = 1'b0; end
        if (e == 8) exp_full = 1'b1;
        if (e == 9) exp_unf = 1'b1;
        es = model(pre, e);
        if (e == 7 && h)      ep = PC_W'(8);
        else if (e == 7 && l) ep = PC_W'(24);
        else if (e == 6 || e == 7) ep = pcv + PC_W'(2);
        else ep = '0;
        @(negedge clk);
        evt = '0;
        chk(req_of(e), 32'(stat), 32'(es));
        chk("R8 enables", 32'(stat[7:6]), 32'(es[7:6]));
        chk((e == 7) ? "R10 address" : "R9 address", 32'(pc_out), 32'(ep));
        chk("R9 strobe", 32'(pc_ld), 32'd1);
        chk("R7 full", 32'(sfull), 32'(exp_full));
        chk("R7 underflow", 32'(sunf), 32'(exp_unf));
        @(negedge clk);
        chk("R9 strobe drop", 32'(pc_ld), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; evt = '0; ghi = 1'b0; glo = 1'b0;
        pc_in = '0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset status", 32'(stat), 32'h1C);
        chk("R1 reset full", 32'(sfull), 32'd0);
        chk("R1 reset underflow", 32'(sunf), 32'd0);
        chk("R1 reset address", 32'(pc_out), 32'd0);
        chk("R9 reset strobe", 32'(pc_ld), 32'd0);

        for (int v = 0; v < 256; v++) begin
            for (int e = 0; e < 10; e++) begin
                logic [PC_W-1:0] pcv;
                pcv = v[3] ? PC_W'((1 << PC_W) - 1 - v) : PC_W'(v * 4093 + e * 77);
                do_write(8'(v));
                fire(e, 8'(v), v[0], v[1], pcv);
            end
        end

        // R11: write together with an event is dropped
        do_write(8'hFF);
        @(negedge clk);
        evt = 10'b00_0010_0000; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        chk("R11 write lost to event", 32'(stat), 32'(model(8'hFF, 5)));

        // R12: two events, lowest index wins
        do_write(8'hDF);
        @(negedge clk);
        evt = 10'b00_0011_0000;
        @(negedge clk);
        evt = '0;
        chk("R12 lowest wins", 32'(stat), 32'(model(8'hDF, 4)));

        // R12: all events set acts as power-on
        do_write(8'h03);
        @(negedge clk);
        evt = '1;
        @(negedge clk);
        evt = '0;
        chk("R12 all set", 32'(stat), 32'h1C);
        chk("R12 all set full", 32'(sfull), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule